// File: doc/BRIEF.md
# Slot-Addressed Multidrop Scan Bridge

This block connects one card to a test bus that is shared by many cards on a backplane. The bus carries the usual scan signals: clock, mode select, serial data in, serial data out and an asynchronous active-low reset. Each bridge runs the standard sixteen-state test access port controller. After reset the bridge waits to be addressed and keeps its serial output disabled. While it waits, every instruction-register update is read as an address. Bits [7:2] of the shifted value are compared with the six strapped slot pins. If they match, the bridge is selected and answers on the bus. A reserved broadcast address selects every bridge at once, so that update events happen on all cards in the same clock cycle.

Once selected, the bridge decodes 8-bit commands. One command makes a mode register the active data path; that register chooses which local scan ports form the chain. A release command sends the bridge back to waiting. Every other command uses a one-bit bypass path. The serial output and its enable are registered on the falling clock edge. The enable is raised only while a selected bridge that was not addressed by broadcast is shifting. An empty slot, or a bridge that is not driving, therefore reads as all ones on the pulled-up bus.

Top module: `scan_bridge`

## Requirements
- R1: After `trst_n` is asserted, the bridge is waiting (`selected` low), `tdo_oe` is low, `mode_sel` equals 8'h01 and the active instruction is bypass.
- R2: On Capture-IR the instruction shift register loads `{slot_addr, 2'b01}`. Bit 0 is shifted out first, and bits [7:2] hold the slot address.
- R3: A waiting bridge becomes selected at Update-IR when bits [7:2] of the shifted value equal `slot_addr`; any other value leaves it waiting. A waiting bridge never drives, so the bus reads all ones.
- R4: Bits [7:2] equal to the broadcast value 6'h3A select every waiting bridge. Under broadcast `tdo_oe` stays low, but commands and data-register updates still take effect.
- R5: A selected bridge that receives instruction 8'h01 returns to waiting at Update-IR.
- R6: Instruction 8'h8E makes the mode register the data path. Capture-DR loads the current mode, shifting runs LSB first, and Update-DR places the shifted value on `mode_sel`.
- R7: Every other instruction, including bypass 8'hFF and the port commands 8'hE7 and 8'hC5, selects a one-bit bypass register. That register captures 0, and `mode_sel` does not change.
- R8: Five TCK rising edges with `tms` high, from any state, reset the bridge to the R1 condition.
- R9: `tdo` and `tdo_oe` change on the falling TCK edge. `tdo_oe` is high only in Shift-IR or Shift-DR of a selected bridge that was not addressed by broadcast.
- R10: Data-register scans on a waiting bridge leave `mode_sel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in from the bus |
| slot_addr | input | 6 | Strapped slot address of this card |
| tdo | output | 1 | Serial data out, valid when `tdo_oe` is high |
| tdo_oe | output | 1 | Output enable for the shared TDO line |
| selected | output | 1 | Bridge has been addressed (directly or by broadcast) |
| mode_sel | output | 8 | Mode register value selecting local scan ports |

## Verification
Address scans use random slot straps paired either with the matching address or with a random mismatching one. This separates the match path from the wait path, and a wrong comparison bit appears as an unexpected drive or as silence. Random mode and bypass data are scanned through a selected bridge. Captured values and one-bit delays distinguish the mode path from the bypass path, and show that the release command actually drops selection. Directed cases cover the broadcast address, where commands must act while the bus stays quiet; the five-TMS reset from a selected, reconfigured state; and data scans on a waiting bridge, which must not touch the mode.

// File: rtl/scan_bridge_pkg.sv
package scan_bridge_pkg;

  localparam int SB_ADDR_W = 6;
  localparam int SB_IR_W   = SB_ADDR_W + 2;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
  } tap_st_e;

  localparam logic [SB_IR_W-1:0] OP_RELEASE   = 8'h01;
  localparam logic [SB_IR_W-1:0] OP_MODE      = 8'h8E;
  localparam logic [SB_IR_W-1:0] OP_PORT_OPEN = 8'hE7;
  localparam logic [SB_IR_W-1:0] OP_PORT_HOLD = 8'hC5;
  localparam logic [SB_IR_W-1:0] OP_BYPASS    = 8'hFF;

  function automatic tap_st_e tap_next(tap_st_e st, logic tms);
    tap_st_e nx;
    case (st)
      ST_RESET:    nx = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nx = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   nx = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   nx = tms ? ST_DR_EX1   : ST_DR_SHIFT;
      ST_DR_SHIFT: nx = tms ? ST_DR_EX1   : ST_DR_SHIFT;
      ST_DR_EX1:   nx = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: nx = tms ? ST_DR_EX2   : ST_DR_PAUSE;
      ST_DR_EX2:   nx = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   nx = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   nx = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   nx = tms ? ST_IR_EX1   : ST_IR_SHIFT;
      ST_IR_SHIFT: nx = tms ? ST_IR_EX1   : ST_IR_SHIFT;
      ST_IR_EX1:   nx = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: nx = tms ? ST_IR_EX2   : ST_IR_PAUSE;
      ST_IR_EX2:   nx = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   nx = tms ? ST_DR_SEL   : ST_IDLE;
      default:     nx = ST_RESET;
    endcase
    return nx;
  endfunction

  // {direct hit, broadcast hit} for an address scanned into a waiting bridge
  function automatic logic [1:0] addr_hit(logic [SB_IR_W-1:0] ir,
                                          logic [SB_ADDR_W-1:0] slot,
                                          logic [SB_ADDR_W-1:0] bcast);
    logic [SB_ADDR_W-1:0] a;
    a = ir[SB_IR_W-1:2];
    return {a == slot, a == bcast};
  endfunction

  function automatic logic [SB_IR_W-1:0] ir_capture(logic [SB_ADDR_W-1:0] slot);
    return {slot, 2'b01};
  endfunction

endpackage

// File: rtl/scan_bridge_tap.sv
module scan_bridge_tap
  import scan_bridge_pkg::*;
(
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  output logic in_reset,
  output logic cap_ir,
  output logic sh_ir,
  output logic upd_ir,
  output logic cap_dr,
  output logic sh_dr,
  output logic upd_dr
);

  tap_st_e st_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st_q <= ST_RESET;
    else         st_q <= tap_next(st_q, tms);
  end

  assign in_reset = (st_q == ST_RESET);
  assign cap_ir   = (st_q == ST_IR_CAP);
  assign sh_ir    = (st_q == ST_IR_SHIFT);
  assign upd_ir   = (st_q == ST_IR_UPD);
  assign cap_dr   = (st_q == ST_DR_CAP);
  assign sh_dr    = (st_q == ST_DR_SHIFT);
  assign upd_dr   = (st_q == ST_DR_UPD);

  // R8: five rising edges with TMS high always end in reset
  a_r8_five_tms_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (tms ##1 tms ##1 tms ##1 tms ##1 tms) |=> (st_q == ST_RESET));

endmodule

// File: rtl/scan_bridge_ir.sv
module scan_bridge_ir
  import scan_bridge_pkg::*;
#(
  parameter logic [SB_ADDR_W-1:0] BCAST_ADDR = 6'h3A
)(
  input  logic                 tck,
  input  logic                 trst_n,
  input  logic                 tdi,
  input  logic [SB_ADDR_W-1:0] slot_addr,
  input  logic                 in_reset,
  input  logic                 cap_ir,
  input  logic                 sh_ir,
  input  logic                 upd_ir,
  output logic                 ir_so,
  output logic                 selected,
  output logic                 bcast,
  output logic [SB_IR_W-1:0]   instr
);

  logic [SB_IR_W-1:0] ir_sr;
  logic [1:0]         hit;
  logic               sel_q, bc_q;
  logic               release_cmd;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     ir_sr <= ir_capture(slot_addr);
    else if (cap_ir) ir_sr <= ir_capture(slot_addr);
    else if (sh_ir)  ir_sr <= {tdi, ir_sr[SB_IR_W-1:1]};
  end

  assign hit         = addr_hit(ir_sr, slot_addr, BCAST_ADDR);
  assign release_cmd = sel_q && upd_ir && (ir_sr == OP_RELEASE);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sel_q <= 1'b0;
      bc_q  <= 1'b0;
      instr <= OP_BYPASS;
    end else if (in_reset) begin
      sel_q <= 1'b0;
      bc_q  <= 1'b0;
      instr <= OP_BYPASS;
    end else if (upd_ir) begin
      if (!sel_q) begin
        sel_q <= |hit;
        bc_q  <= hit[0] && !hit[1];
        instr <= OP_BYPASS;
      end else if (release_cmd) begin
        sel_q <= 1'b0;
        bc_q  <= 1'b0;
        instr <= OP_BYPASS;
      end else begin
        instr <= ir_sr;
      end
    end
  end

  assign ir_so    = ir_sr[0];
  assign selected = sel_q;
  assign bcast    = bc_q;

  // R3: selection only starts at an instruction update
  a_r3_select_on_update: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(sel_q) |-> $past(upd_ir));

  // R5: the release command drops selection on the next cycle
  a_r5_release_drops: assert property (@(posedge tck) disable iff (!trst_n)
    (sel_q && upd_ir && (ir_sr == OP_RELEASE)) |=> !sel_q);

  // R4: broadcast is only ever held while selected
  a_r4_bcast_implies_sel: assert property (@(posedge tck) disable iff (!trst_n)
    bc_q |-> sel_q);

endmodule

// File: rtl/scan_bridge_dr.sv
module scan_bridge_dr #(
  parameter int             MODE_W   = 8,
  parameter logic [MODE_W-1:0] MODE_RST = 1
)(
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  logic              in_reset,
  input  logic              cap_dr,
  input  logic              sh_dr,
  input  logic              upd_dr,
  input  logic              mode_path,
  output logic              dr_so,
  output logic [MODE_W-1:0] mode_q
);

  logic              byp_q;
  logic [MODE_W-1:0] mode_sr;
  logic              mode_load;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     byp_q <= 1'b0;
    else if (cap_dr) byp_q <= 1'b0;
    else if (sh_dr)  byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                     mode_sr <= MODE_RST;
    else if (cap_dr && mode_path)    mode_sr <= mode_q;
    else if (sh_dr && mode_path)     mode_sr <= {tdi, mode_sr[MODE_W-1:1]};
  end

  assign mode_load = upd_dr && mode_path;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        mode_q <= MODE_RST;
    else if (in_reset)  mode_q <= MODE_RST;
    else if (mode_load) mode_q <= mode_sr;
  end

  assign dr_so = mode_path ? mode_sr[0] : byp_q;

  // R10 / R7: the mode only moves on a mode update or a reset
  a_r10_mode_hold: assert property (@(posedge tck) disable iff (!trst_n)
    (!mode_load && !in_reset) |=> $stable(mode_q));

endmodule

// File: rtl/scan_bridge.sv
module scan_bridge
  import scan_bridge_pkg::*;
#(
  parameter int                   MODE_W     = 8,
  parameter logic [MODE_W-1:0]    MODE_RST   = 1,
  parameter logic [SB_ADDR_W-1:0] BCAST_ADDR = 6'h3A
)(
  input  logic                 tck,
  input  logic                 trst_n,
  input  logic                 tms,
  input  logic                 tdi,
  input  logic [SB_ADDR_W-1:0] slot_addr,
  output logic                 tdo,
  output logic                 tdo_oe,
  output logic                 selected,
  output logic [MODE_W-1:0]    mode_sel
);

  logic in_reset, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr;
  logic ir_so, dr_so, bcast, mode_path;
  logic [SB_IR_W-1:0] instr;

  scan_bridge_tap u_tap (
    .tck(tck), .trst_n(trst_n), .tms(tms),
    .in_reset(in_reset), .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
    .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr)
  );

  scan_bridge_ir #(.BCAST_ADDR(BCAST_ADDR)) u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .slot_addr(slot_addr),
    .in_reset(in_reset), .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
    .ir_so(ir_so), .selected(selected), .bcast(bcast), .instr(instr)
  );

  assign mode_path = selected && (instr == OP_MODE);

  scan_bridge_dr #(.MODE_W(MODE_W), .MODE_RST(MODE_RST)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .in_reset(in_reset),
    .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr), .mode_path(mode_path),
    .dr_so(dr_so), .mode_q(mode_sel)
  );

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b1;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= sh_ir ? ir_so : dr_so;
      tdo_oe <= (sh_ir || sh_dr) && selected && !bcast;
    end
  end

  // R9: the line is driven only by a directly addressed bridge
  a_r9_oe_needs_direct_sel: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (selected && !bcast));

  // R1 / R9: nothing is driven in the reset state
  a_r1_quiet_in_reset: assert property (@(posedge tck) disable iff (!trst_n)
    in_reset |=> !tdo_oe);

endmodule

// File: tb/test_scan_bridge.sv
module test_scan_bridge;

  localparam logic [5:0] BC   = 6'h3A;
  localparam logic [7:0] C_RELEASE = 8'h01;
  localparam logic [7:0] C_MODE    = 8'h8E;
  localparam logic [7:0] C_BYPASS  = 8'hFF;
  localparam logic [7:0] C_OPEN    = 8'hE7;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic [5:0] slot = 6'h15;
  logic       tdo, tdo_oe, selected;
  logic [7:0] mode_sel;

  int n_run = 0;
  int n_fail = 0;

  always #4 tck = ~tck;

  scan_bridge i_scan_bridge (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .slot_addr(slot),
    .tdo(tdo), .tdo_oe(tdo_oe), .selected(selected), .mode_sel(mode_sel)
  );

  function automatic logic [7:0] f_cap(logic [5:0] s);
    return {s, 1'b0, 1'b1};
  endfunction

  function automatic logic [7:0] f_byp(logic [7:0] d);
    return d << 1;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic bus);
    @(negedge tck);
    #1;
    bus = tdo_oe ? tdo : 1'b1;
    tms = m;
    tdi = d;
    @(posedge tck);
  endtask

  task automatic settle();
    @(negedge tck);
    #1;
  endtask

  task automatic do_reset(input logic [5:0] s);
    logic b;
    trst_n = 1'b0;
    tms = 1'b1;
    slot = s;
    #20;
    trst_n = 1'b1;
    tick(1'b0, 1'b0, b);
  endtask

  task automatic scan_ir(input logic [7:0] v, output logic [7:0] o);
    logic b;
    tick(1, 0, b); tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
    for (int i = 0; i < 8; i++) begin
      tick(i == 7, v[i], b);
      o[i] = b;
    end
    tick(1, 0, b); tick(0, 0, b);
  endtask

  task automatic scan_dr(input logic [7:0] v, output logic [7:0] o);
    logic b;
    tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
    for (int i = 0; i < 8; i++) begin
      tick(i == 7, v[i], b);
      o[i] = b;
    end
    tick(1, 0, b); tick(0, 0, b);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] o;
    logic       b;
    int unsigned seed;
    seed = $urandom(32'd2024);

    // R1: reset state
    do_reset(6'h15);
    settle();
    check("R1 selected", {15'd0, selected}, 16'd0);
    check("R1 tdo_oe", {15'd0, tdo_oe}, 16'd0);
    check("R1 mode", {8'd0, mode_sel}, 16'h0001);

    // R10: DR scan while waiting leaves mode and bus untouched
    scan_dr(8'h5A, o);
    check("R10 bus", {8'd0, o}, 16'h00FF);
    settle();
    check("R10 mode", {8'd0, mode_sel}, 16'h0001);

    // R3 / R2: direct select, then capture readback
    scan_ir({6'h15, 2'b10}, o);
    check("R3 bus while waiting", {8'd0, o}, 16'h00FF);
    settle();
    check("R3 selected", {15'd0, selected}, 16'd1);
    check("R9 idle quiet", {15'd0, tdo_oe}, 16'd0);
    scan_ir(C_OPEN, o);
    check("R2 capture", {8'd0, o}, {8'd0, f_cap(6'h15)});
    scan_dr(8'hC3, o);
    check("R7 port cmd bypass", {8'd0, o}, {8'd0, f_byp(8'hC3)});

    // R8: configure mode, then five TMS-high edges
    scan_ir(C_MODE, o);
    scan_dr(8'h3C, o);
    settle();
    check("R6 mode load", {8'd0, mode_sel}, 16'h003C);
    for (int i = 0; i < 5; i++) tick(1, 0, b);
    tick(0, 0, b);
    settle();
    check("R8 selected", {15'd0, selected}, 16'd0);
    check("R8 mode", {8'd0, mode_sel}, 16'h0001);

    // R4: broadcast select, quiet bus, commands still act
    do_reset(6'h15);
    scan_ir({BC, 2'b00}, o);
    settle();
    check("R4 selected", {15'd0, selected}, 16'd1);
    scan_ir(C_MODE, o);
    check("R4 ir quiet", {8'd0, o}, 16'h00FF);
    scan_dr(8'hA5, o);
    check("R4 dr quiet", {8'd0, o}, 16'h00FF);
    settle();
    check("R4 mode", {8'd0, mode_sel}, 16'h00A5);
    scan_ir(C_RELEASE, o);
    settle();
    check("R5 bcast release", {15'd0, selected}, 16'd0);

    // Random slots and addresses
    for (int it = 0; it < 24; it++) begin
      logic [5:0] s, a, a2;
      logic [7:0] m, d;
      logic       exp_sel;
      s = 6'($urandom % 64);
      while (s == BC) s = 6'($urandom % 64);
      if ($urandom % 2) a = s;
      else begin
        a = 6'($urandom % 64);
        while (a == s || a == BC) a = 6'($urandom % 64);
      end
      exp_sel = (a == s);
      do_reset(s);
      scan_ir({a, 2'($urandom % 4)}, o);
      check("R3 bus while waiting", {8'd0, o}, 16'h00FF);
      settle();
      check("R3 match", {15'd0, selected}, {15'd0, exp_sel});
      if (exp_sel) begin
        m = 8'($urandom);
        d = 8'($urandom);
        scan_ir(C_MODE, o);
        check("R2 capture", {8'd0, o}, {8'd0, f_cap(s)});
        scan_dr(m, o);
        check("R6 captured mode", {8'd0, o}, 16'h0001);
        settle();
        check("R6 mode", {8'd0, mode_sel}, {8'd0, m});
        scan_ir(C_BYPASS, o);
        check("R2 capture", {8'd0, o}, {8'd0, f_cap(s)});
        scan_dr(d, o);
        check("R7 bypass", {8'd0, o}, {8'd0, f_byp(d)});
        settle();
        check("R7 mode kept", {8'd0, mode_sel}, {8'd0, m});
        scan_ir(C_RELEASE, o);
        settle();
        check("R5 release", {15'd0, selected}, 16'd0);
        scan_dr(8'h00, o);
        check("R10 bus", {8'd0, o}, 16'h00FF);
        settle();
        check("R10 mode", {8'd0, mode_sel}, {8'd0, m});
        a2 = (s == 6'h3B) ? (s ^ 6'h02) : (s ^ 6'h01);
        scan_ir({a2, 2'b00}, o);
        check("R5 waiting again", {8'd0, o}, 16'h00FF);
        settle();
        check("R3 mismatch", {15'd0, selected}, 16'd0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule